// File: doc/BRIEF.md
# Edge-Latching Bridge Interrupt Controller

This block is a secondary interrupt controller that sits between a bank of event sources and one input of a parent interrupt controller. Each source line is synchronized into the block's clock domain, and a low-to-high transition on it sets a sticky pending bit. The pending bits are combined with a per-source enable word, and the result drives a single registered summary request toward the parent.

Software reads the pending word to find out which sources fired, and acknowledges them by writing zeros into that word. Pending bits latch even while their source is disabled. The safe way to enable a source is therefore to clear its pending bit first and to set its enable bit after that, so that an event left over from earlier does not raise the summary.

The number of live sources is a parameter of up to 32. Bit positions at and above that count read as zero and cannot be set.

Top module: `edge_irq_bridge`

## Requirements
- R1: After reset the pending word, the enable word and `irq_out` are all zero.
- R2: If a source input goes from 0 to 1 and stays high, its pending bit reads 1 after the third rising clock edge that follows the change. Two of those edges are synchronizer stages and one is edge detection.
- R3: A pending bit stays set after its source falls. A source that is held high sets its bit only once, so after an acknowledge the bit stays clear until a new low-to-high transition.
- R4: A pending bit latches its event even while the enable bit of that source is 0.
- R5: A write to byte address 0x00 acts on the pending word. Each 0 data bit clears the matching pending bit, and each 1 data bit leaves it unchanged. All-zero data clears every pending bit.
- R6: If a clear and a newly detected edge reach the same pending bit in the same cycle, the bit ends up set.
- R7: A write to byte address 0x04 loads the enable word, where 1 enables a source. Reading 0x04 returns that word. The enable word changes only on such a write.
- R8: `irq_out` is registered. After each clock edge it equals the OR over all bits of (pending AND enable) as they stood before that edge.
- R9: Pending and enable bits at positions NUM_SRC and above always read 0. Reads from any address other than 0x00 and 0x04 return 0, and writes to such addresses change nothing.
- R10: A 1-to-0 transition of a source never sets its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Asynchronous event source lines |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Summary interrupt request toward the parent |

## Verification
The assertions assume that `src_in` is held low while reset is asserted. They also assume that `reg_wr` is a one-cycle strobe that is sampled only on rising edges. The bench drives every input on the falling edge and keeps all sources low through reset. This means no spurious edge is detected when reset is released, and a pending bit can change only through a detected edge or a write to the pending word. The random phase never leaves these conditions: it toggles source lines and issues writes to valid and invalid addresses freely, but only between clock edges.

// File: rtl/edge_irq_bridge.sv
module edge_irq_bridge #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);

  localparam logic [ADDR_W-1:0] ADDR_PEND = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] ADDR_ENAB = ADDR_W'(8'h04);

  logic [NUM_SRC-1:0] sync1, sync2, hist;
  logic [NUM_SRC-1:0] pend, enab;
  logic [NUM_SRC-1:0] rise;
  logic               wr_pend, wr_enab;

  assign rise    = sync2 & ~hist;
  assign wr_pend = reg_wr && (reg_addr == ADDR_PEND);
  assign wr_enab = reg_wr && (reg_addr == ADDR_ENAB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      hist  <= '0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
      hist  <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      enab    <= '0;
      irq_out <= 1'b0;
    end else begin
      pend    <= (wr_pend ? (pend & reg_wdata[NUM_SRC-1:0]) : pend) | rise;
      if (wr_enab) enab <= reg_wdata[NUM_SRC-1:0];
      irq_out <= |(pend & enab);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_PEND)      reg_rdata[NUM_SRC-1:0] = pend;
    else if (reg_addr == ADDR_ENAB) reg_rdata[NUM_SRC-1:0] = enab;
  end

  AST_PEND_SET_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(rise)) == '0)); // R2

  AST_PEND_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend) & ~pend)) |-> $past(wr_pend)); // R5

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rise) & ~pend) == '0)); // R6

  AST_ENAB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_enab) |-> $stable(enab)); // R7

  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|(pend & enab))); // R8

  AST_FALL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(sync2)) == '0)); // R10

endmodule

// File: tb/tb_edge_irq_bridge.sv
`timescale 1ns/1ps
module tb_edge_irq_bridge;
  localparam int NS = 20;
  localparam logic [31:0] VALID = (32'd1 << NS) - 1;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NS-1:0] src_in = '0;
  logic          reg_wr = 0;
  logic [7:0]    reg_addr = 8'h00;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_out;

  int checks = 0, fails = 0;

  edge_irq_bridge #(.NUM_SRC(NS)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out));

  always #5 clk = ~clk;

  // behavioural model: queue of past source samples, oldest first
  logic [31:0] q[$];
  logic [31:0] m_pend, m_enab;
  bit          m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_enab = 0; m_irq = 0;
      q = {32'd0, 32'd0, 32'd0};
    end else begin
      logic [31:0] evt;
      evt = q[1] & ~q[0];
      m_irq = |(m_pend & m_enab);
      if (reg_wr && reg_addr == 8'h00) m_pend = m_pend & reg_wdata;
      m_pend = (m_pend | evt) & VALID;
      if (reg_wr && reg_addr == 8'h04) m_enab = reg_wdata & VALID;
      void'(q.pop_front());
      q.push_back(32'(src_in));
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h00) return m_pend;
    if (a == 8'h04) return m_enab;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      chk("R8 model irq", 32'(irq_out), 32'(m_irq));
      chk("R9 model read", reg_rdata, m_read(reg_addr));
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rd(logic [7:0] a, string tag, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    ticks(3);
    rst_n = 1;
    tick();
    rd(8'h00, "R1 pend reset", 0);
    rd(8'h04, "R1 enab reset", 0);
    chk("R1 irq reset", 32'(irq_out), 0);

    src_in[3] = 1; src_in[5] = 1;
    ticks(2);
    rd(8'h00, "R2 not yet", 0);
    tick();
    rd(8'h00, "R2 R4 latched while disabled", 32'h28);
    chk("R4 irq stays low", 32'(irq_out), 0);

    src_in[3] = 0; src_in[5] = 0;
    ticks(4);
    rd(8'h00, "R3 R10 sticky after fall", 32'h28);

    wr(8'h00, 32'hFFFF_FFF7);
    rd(8'h00, "R5 zero clears one bit", 32'h20);

    wr(8'h04, 32'h20);
    chk("R8 irq one cycle later", 32'(irq_out), 0);
    tick();
    chk("R8 irq asserted", 32'(irq_out), 1);
    rd(8'h04, "R7 enable readback", 32'h20);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, "R9 unused enable bits", VALID);

    wr(8'h00, 32'h0);
    rd(8'h00, "R5 all zero clears", 0);
    tick();
    chk("R8 irq drops", 32'(irq_out), 0);

    src_in[7] = 1;
    ticks(3);
    rd(8'h00, "R2 level source", 32'h80);
    wr(8'h00, 32'h0);
    ticks(5);
    rd(8'h00, "R3 held level no retrigger", 0);

    src_in[9] = 1;
    ticks(2);
    wr(8'h00, 32'h0);
    rd(8'h00, "R6 edge wins over clear", 32'h200);

    wr(8'h08, 32'h0);
    rd(8'h00, "R9 stray write ignored", 32'h200);
    rd(8'h08, "R9 stray read zero", 0);
    rd(8'h04, "R7 enable unchanged", VALID);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      src_in = NS'($urandom);
      if (r < 2) begin
        reg_wr = 1; reg_addr = 8'h00; reg_wdata = $urandom;
      end else if (r == 2) begin
        reg_wr = 1; reg_addr = 8'h04; reg_wdata = $urandom;
      end else if (r == 3) begin
        reg_wr = 1; reg_addr = 8'h0C; reg_wdata = $urandom;
      end else begin
        reg_wr = 0; reg_addr = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'h04;
      end
      tick();
      reg_wr = 0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule